// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a serial audio stream into parallel samples. The stream arrives on one data pin and is timed by a bit clock and a frame clock that another device drives. All three pins are sampled by the block's system clock, so they must already be synchronous to it. Each bit-clock phase, high and low, must last at least two system clock cycles. The block sees a bit on every rising edge of the bit clock. It finds frame and half-frame boundaries from the frame clock and collects the bits of each channel slot into a 24-bit two's-complement sample. For every slot it completes, it outputs that sample with its channel number and a one-cycle valid strobe.

Five framings are handled by one datapath. Three are two-channel: the I2S framing, left-justified and right-justified. Two are time-division: one with a frame clock of 50% duty cycle and one with a frame pulse that is a single bit wide. Configuration inputs choose the framing, invert the frame clock, set the number of time-division slots and set the right-justified delay. The configuration is changed only while the block is held in reset.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released, `out_valid` is 0 and `out_sample` and `out_chan` are all zero.
- R2: Bits arrive MSB first. A word is left-aligned in `out_sample`: the first bit received goes to bit 23. A word shorter than 24 bits has its unused low bits set to zero.
- R3: When a word has more than 24 bits, the bits after the 24th are discarded. The first 24 bits are still output unchanged.
- R4: With `cfg_fmt` = 0 (I2S framing), a frame starts at a falling edge of the frame clock and a half-frame starts at a rising edge. The MSB is the bit sampled on the second bit clock after the edge. The low half has channel 0 and the high half has channel 1.
- R5: With `cfg_fmt` = 1 (left-justified), a frame starts at a rising frame-clock edge, and the bit sampled on that same bit clock is the MSB. The high half has channel 0 and the low half has channel 1.
- R6: With `cfg_fmt` = 2 (right-justified), the first data bit is sampled 8, 12 or 16 bit clocks after a frame-clock edge, for `cfg_rj_delay` = 0, 1 or 2. In a 64-clock frame this gives words of 24, 20 or 16 bits. Edges and channels are the same as in R5.
- R7: With `cfg_fmt` = 3 (time-division, 50% frame clock), a rising edge starts slot 0 and a falling edge starts slot N/2. N is 2, 4 or 8 for `cfg_slots` = 0, 1 or 2. Data starts one bit clock after the edge, and each slot is 32 bit clocks long.
- R8: With `cfg_fmt` = 4 (time-division, one-bit frame pulse), a rising edge of the pulse starts slot 0. Bit clocks that come after the last of the N slots are ignored, so any frame length is accepted.
- R9: With `cfg_fclk_inv` = 1, the frame clock is inverted before any edge is found.
- R10: Each completed slot produces exactly one valid pulse, one cycle long. A time-division slot is reported as soon as its 24th bit is sampled. A two-channel word is reported at the frame-clock edge that ends it.
- R11: A time-division frame start that arrives before the current slot has 24 bits drops that partial slot and starts counting again at slot 0.
- R12: After reset, no data bit is captured and no sample is produced until the first frame-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples every serial pin |
| rst_n | input | 1 | Synchronous reset, active low |
| bclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| fclk | input | 1 | Frame clock or frame pulse |
| sdata | input | 1 | Serial data |
| cfg_fmt | input | 3 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM 50% clock, 4 TDM pulse |
| cfg_fclk_inv | input | 1 | 1 inverts the frame clock |
| cfg_slots | input | 2 | Time-division slot count: 0→2, 1→4, 2→8 |
| cfg_rj_delay | input | 2 | Right-justified delay: 0→8, 1→12, 2→16 bit clocks |
| out_valid | output | 1 | One-cycle strobe for a completed slot |
| out_sample | output | 24 | Left-aligned two's-complement sample |
| out_chan | output | 3 | Channel or slot index of the sample |

## Verification
Any error in the bit counter, the slot counter or the tracked frame-clock level shows at the ports within one slot. A wrong count shifts the sample word, so it appears as a sample off by one or more bit positions. A wrong slot counter gives a wrong channel number. A wrong edge state gives too many or too few valid pulses in the frame. The bench compares every reported sample, in order, with a model built from the bits it sent. It also compares the number of samples in each stream with the expected count, so a missing or extra pulse is found at the end of the stream in which it occurs.

// File: rtl/aud_rx_pkg.sv
// Shared types for the serial audio receiver.
package aud_rx_pkg;
    // Framing selector codes; the values are visible on cfg_fmt.
    typedef enum logic [2:0] {
        FMT_I2S       = 3'd0,
        FMT_LJ        = 3'd1,
        FMT_RJ        = 3'd2,
        FMT_TDM_CLK   = 3'd3,
        FMT_TDM_PULSE = 3'd4
    } fmt_e;
endpackage

// File: rtl/aud_rx_front.sv
// Front end: registers the serial pins in the system clock domain,
// detects rising bit-clock edges (ticks) and classifies frame-clock
// edges as frame starts or half-frame starts for the selected framing.
// Assumes pins are synchronous to clk and each bclk phase lasts >= 2 cycles.
module aud_rx_front
    import aud_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fclk,
    input  logic sdata,
    input  logic fclk_inv,
    input  fmt_e fmt,
    output logic tick,
    output logic dbit,
    output logic start_edge,
    output logic mid_edge
);
    logic bclk_q, bclk_qq, fclk_q, sd_q;
    logic f_prev, primed;
    logic f_now, rise, fall;

    // Register the pins and remember the frame level seen at the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            bclk_qq <= 1'b0;
            fclk_q  <= 1'b0;
            sd_q    <= 1'b0;
            f_prev  <= 1'b0;
            primed  <= 1'b0;
        end else begin
            bclk_q  <= bclk;
            bclk_qq <= bclk_q;
            fclk_q  <= fclk;
            sd_q    <= sdata;
            if (tick) begin
                f_prev <= f_now;
                primed <= 1'b1;
            end
        end
    end

    // Tick and frame-clock transitions sampled at the tick.
    always_comb begin
        tick  = bclk_q & ~bclk_qq;
        dbit  = sd_q;
        f_now = fclk_q ^ fclk_inv;
        rise  = tick & primed & f_now & ~f_prev;
        fall  = tick & primed & ~f_now & f_prev;
    end

    // Map transitions onto frame and half-frame starts per framing.
    always_comb begin
        case (fmt)
            FMT_I2S: begin
                start_edge = fall;
                mid_edge   = rise;
            end
            FMT_LJ, FMT_RJ, FMT_TDM_CLK: begin
                start_edge = rise;
                mid_edge   = fall;
            end
            default: begin
                start_edge = rise;
                mid_edge   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/aud_rx_framer.sv
// Framer: tracks the bit position since the last frame-clock edge, the
// slot index and the bit count within the slot, and issues write, clear
// and emit controls to the word assembler. Assumes configuration is
// stable while out of reset and SLOT_W > DW.
module aud_rx_framer
    import aud_rx_pkg::*;
#(
    parameter int DW        = 24,
    parameter int SLOT_W    = 32,
    parameter int MAX_SLOTS = 8,
    localparam int CW       = $clog2(MAX_SLOTS),
    localparam int IW       = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start_edge,
    input  logic          mid_edge,
    input  fmt_e          fmt,
    input  logic [1:0]    slots_code,
    input  logic [1:0]    rj_code,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic          wr_new,
    output logic          clr,
    output logic          emit,
    output logic [CW-1:0] emit_chan
);
    localparam int SW      = CW + 1;
    localparam int MAXB    = (SLOT_W > DW) ? SLOT_W : DW;
    localparam int BW      = $clog2(MAXB + 1);
    localparam int PW      = 5;
    localparam logic [PW-1:0] POS_MAX = '1;

    logic          active, active_n;
    logic [PW-1:0] pos, pos_n;
    logic [BW-1:0] bitn, bitn_n;
    logic [CW-1:0] slot, slot_n;

    logic [PW-1:0] delay;
    logic [SW-1:0] slots_n, half_n, limit;
    logic          two_ch, in_data;

    // Decode framing-dependent constants.
    always_comb begin
        case (fmt)
            FMT_LJ: delay = PW'(0);
            FMT_RJ: begin
                case (rj_code)
                    2'd0:    delay = PW'(8);
                    2'd1:    delay = PW'(12);
                    default: delay = PW'(16);
                endcase
            end
            default: delay = PW'(1);
        endcase
        case (slots_code)
            2'd0:    slots_n = SW'(2);
            2'd1:    slots_n = SW'(4);
            default: slots_n = SW'(MAX_SLOTS);
        endcase
        half_n  = slots_n >> 1;
        two_ch  = fmt inside {FMT_I2S, FMT_LJ, FMT_RJ};
        in_data = (pos >= delay);
        limit   = (fmt == FMT_TDM_CLK && {1'b0, slot} < half_n) ? half_n : slots_n;
    end

    // Next-state and control decode for one bit-clock tick.
    always_comb begin
        active_n  = active;
        pos_n     = pos;
        bitn_n    = bitn;
        slot_n    = slot;
        wr_en     = 1'b0;
        wr_new    = 1'b0;
        clr       = 1'b0;
        emit      = 1'b0;
        emit_chan = slot;
        wr_idx    = IW'(DW - 1) - bitn[IW-1:0];
        if (tick) begin
            if (start_edge || mid_edge) begin
                if (active && two_ch) begin
                    if (fmt == FMT_I2S && in_data && bitn < BW'(DW)) begin
                        wr_en = 1'b1;
                        emit  = 1'b1;
                    end else begin
                        emit = (bitn != '0);
                    end
                end
                clr      = 1'b1;
                active_n = 1'b1;
                pos_n    = PW'(1);
                slot_n   = start_edge ? '0 : (two_ch ? CW'(1) : CW'(half_n));
                if (delay == '0) begin
                    wr_new = 1'b1;
                    bitn_n = BW'(1);
                end else begin
                    bitn_n = '0;
                end
            end else if (active) begin
                if (pos != POS_MAX) pos_n = pos + PW'(1);
                if (in_data) begin
                    if (two_ch) begin
                        if (bitn < BW'(DW)) begin
                            wr_en  = 1'b1;
                            bitn_n = bitn + BW'(1);
                        end
                    end else begin
                        if (bitn < BW'(DW)) wr_en = 1'b1;
                        if (bitn == BW'(DW - 1)) emit = 1'b1;
                        if (bitn == BW'(SLOT_W - 1)) begin
                            bitn_n = '0;
                            clr    = 1'b1;
                            if (({1'b0, slot} + SW'(1)) >= limit) active_n = 1'b0;
                            else slot_n = slot + CW'(1);
                        end else begin
                            bitn_n = bitn + BW'(1);
                        end
                    end
                end
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pos    <= '0;
            bitn   <= '0;
            slot   <= '0;
        end else begin
            active <= active_n;
            pos    <= pos_n;
            bitn   <= bitn_n;
            slot   <= slot_n;
        end
    end
endmodule

// File: rtl/aud_rx_assembler.sv
// Word assembler: places each captured bit at its left-aligned position,
// hands the finished word to the registered output on emit, and clears
// the word for the next slot. Unwritten low bits stay zero.
module aud_rx_assembler #(
    parameter int DW = 24,
    parameter int CW = 3,
    localparam int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbit,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_new,
    input  logic          clr,
    input  logic          emit,
    input  logic [CW-1:0] emit_chan,
    output logic          out_valid,
    output logic [DW-1:0] out_sample,
    output logic [CW-1:0] out_chan
);
    logic [DW-1:0] word, word_pre, word_post;

    // Bit written into the ending word, then optional clear and new MSB.
    always_comb begin
        word_pre = word;
        if (wr_en) word_pre[wr_idx] = dbit;
        word_post = clr ? '0 : word_pre;
        if (wr_new) word_post[DW-1] = dbit;
    end

    // Hold the word under construction and the output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word       <= '0;
            out_valid  <= 1'b0;
            out_sample <= '0;
            out_chan   <= '0;
        end else begin
            word      <= word_post;
            out_valid <= emit;
            if (emit) begin
                out_sample <= word_pre;
                out_chan   <= emit_chan;
            end
        end
    end
endmodule

// File: rtl/aud_serial_rx.sv
// Top level of the multi-format serial audio receiver: front end,
// framer and word assembler in a chain. Pins must be synchronous to clk;
// configuration changes only under reset.
module aud_serial_rx
    import aud_rx_pkg::*;
#(
    parameter int DW        = 24,
    parameter int SLOT_W    = 32,
    parameter int MAX_SLOTS = 8,
    localparam int CH_W     = $clog2(MAX_SLOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bclk,
    input  logic            fclk,
    input  logic            sdata,
    input  logic [2:0]      cfg_fmt,
    input  logic            cfg_fclk_inv,
    input  logic [1:0]      cfg_slots,
    input  logic [1:0]      cfg_rj_delay,
    output logic            out_valid,
    output logic [DW-1:0]   out_sample,
    output logic [CH_W-1:0] out_chan
);
    localparam int IW = $clog2(DW);

    fmt_e            fmt;
    logic            tick, dbit, start_edge, mid_edge;
    logic            wr_en, wr_new, clr, emit;
    logic [IW-1:0]   wr_idx;
    logic [CH_W-1:0] emit_chan;

    // Interpret the raw framing code.
    always_comb fmt = fmt_e'(cfg_fmt);

    aud_rx_front u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk),
        .fclk       (fclk),
        .sdata      (sdata),
        .fclk_inv   (cfg_fclk_inv),
        .fmt        (fmt),
        .tick       (tick),
        .dbit       (dbit),
        .start_edge (start_edge),
        .mid_edge   (mid_edge)
    );

    aud_rx_framer #(.DW(DW), .SLOT_W(SLOT_W), .MAX_SLOTS(MAX_SLOTS)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start_edge (start_edge),
        .mid_edge   (mid_edge),
        .fmt        (fmt),
        .slots_code (cfg_slots),
        .rj_code    (cfg_rj_delay),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_new     (wr_new),
        .clr        (clr),
        .emit       (emit),
        .emit_chan  (emit_chan)
    );

    aud_rx_assembler #(.DW(DW), .CW(CH_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dbit       (dbit),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_new     (wr_new),
        .clr        (clr),
        .emit       (emit),
        .emit_chan  (emit_chan),
        .out_valid  (out_valid),
        .out_sample (out_sample),
        .out_chan   (out_chan)
    );
endmodule

// File: rtl/aud_serial_rx_chk.sv
// Port-level properties of the serial audio receiver, bound to the top.
module aud_serial_rx_chk #(
    parameter int DW   = 24,
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      cfg_fmt,
    input logic [1:0]      cfg_slots,
    input logic [1:0]      cfg_rj_delay,
    input logic            out_valid,
    input logic [DW-1:0]   out_sample,
    input logic [CH_W-1:0] out_chan
);
    logic [CH_W:0] slot_lim;

    // Slot count selected by configuration.
    always_comb begin
        case (cfg_slots)
            2'd0:    slot_lim = (CH_W+1)'(2);
            2'd1:    slot_lim = (CH_W+1)'(4);
            default: slot_lim = (CH_W+1)'(8);
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_sample == '0)); // R1
    AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R10
    AST_TWO_CH_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_fmt <= 3'd2) |-> (out_chan <= CH_W'(1))); // R4
    AST_TDM_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (cfg_fmt == 3'd3 || cfg_fmt == 3'd4)) |-> ({1'b0, out_chan} < slot_lim)); // R7
    AST_RJ16_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_fmt == 3'd2 && cfg_rj_delay == 2'd2) |-> (out_sample[DW-17:0] == '0)); // R6
    AST_RJ20_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_fmt == 3'd2 && cfg_rj_delay == 2'd1) |-> (out_sample[DW-21:0] == '0)); // R6
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.DW(DW), .CH_W(CH_W)) u_chk (.*);

// File: tb/aud_serial_rx_bench.sv
module aud_serial_rx_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, fclk = 1'b0, sdata = 1'b0;
    logic [2:0]  cfg_fmt = '0;
    logic        cfg_fclk_inv = 1'b0;
    logic [1:0]  cfg_slots = '0, cfg_rj_delay = '0;
    logic        out_valid;
    logic [23:0] out_sample;
    logic [2:0]  out_chan;

    aud_serial_rx u_aud_serial_rx (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fclk(fclk), .sdata(sdata),
        .cfg_fmt(cfg_fmt), .cfg_fclk_inv(cfg_fclk_inv), .cfg_slots(cfg_slots),
        .cfg_rj_delay(cfg_rj_delay), .out_valid(out_valid),
        .out_sample(out_sample), .out_chan(out_chan)
    );

    int n_vec = 0, n_bad = 0;
    logic [23:0] got_s [0:1023];
    logic [2:0]  got_c [0:1023];
    int          n_got = 0;
    logic [23:0] exp_s [0:255];
    logic [2:0]  exp_c [0:255];
    int          n_exp;
    logic [23:0] wbuf [0:7];
    logic [7:0]  jbuf [0:7];

    // Collect every reported sample away from the active edge.
    always @(negedge clk) begin
        if (out_valid) begin
            got_s[n_got % 1024] = out_sample;
            got_c[n_got % 1024] = out_chan;
            n_got = n_got + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic bit lvl_of(input int fmt, input int t, input int n);
        case (fmt)
            0:       return t >= n / 2;
            4:       return t == 0;
            default: return t < n / 2;
        endcase
    endfunction

    function automatic bit word_bit(input int s, input int k, input int wl);
        if (k < 0 || k >= wl) return 1'b0;
        if (k < 24) return wbuf[s][23 - k];
        return jbuf[s][k - 24];
    endfunction

    function automatic bit dat_of(input int fmt, input int t, input int n,
                                  input int wl, input int d, input int slots);
        int h, p, s;
        if (fmt <= 2) begin
            h = t / 32;
            p = t % 32;
            case (fmt)
                0:       return (p == 0) ? 1'b0 : word_bit(h, p - 1, wl);
                1:       return word_bit(h, p, wl);
                default: return word_bit(h, p - d, wl);
            endcase
        end
        if (t == 0) return 1'b0;
        p = t - 1;
        s = p / 32;
        if (s >= slots) return 1'b0;
        return word_bit(s, p % 32, wl);
    endfunction

    task automatic drive_tick(input bit lvl, input bit d);
        bclk  = 1'b0;
        fclk  = lvl ^ cfg_fclk_inv;
        sdata = d;
        repeat (2) @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One configured stream: reset, lead-in, frames, closing edge, compare.
    task automatic run_stream(input int fmt, input bit inv, input int sc, input int rc,
                              input int wl_in, input int nfr, input int n, input string req);
        int d, slots, wl, base, cnt;
        logic [23:0] w;
        @(negedge clk);
        cfg_fmt = 3'(fmt); cfg_fclk_inv = inv; cfg_slots = 2'(sc); cfg_rj_delay = 2'(rc);
        d     = (fmt == 1) ? 0 : (fmt == 2) ? (rc == 0 ? 8 : rc == 1 ? 12 : 16) : 1;
        slots = (sc == 0) ? 2 : (sc == 1) ? 4 : 8;
        wl    = (fmt == 2) ? 32 - d : wl_in;
        bclk  = 1'b0;
        fclk  = lvl_of(fmt, n - 1, n) ^ inv;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        base  = n_got;
        n_exp = 0;
        // R12: lead-in bits before any frame edge must not be captured.
        for (int i = 0; i < 3; i++) drive_tick(lvl_of(fmt, n - 1, n), 1'($urandom));
        for (int f = 0; f < nfr; f++) begin
            for (int s = 0; s < 8; s++) begin
                w = 24'($urandom);
                if (wl < 24) w = w & ~((24'd1 << (24 - wl)) - 24'd1);
                wbuf[s] = w;
                jbuf[s] = 8'($urandom);
            end
            if (fmt <= 2) begin
                for (int h = 0; h < 2; h++) begin
                    exp_s[n_exp] = wbuf[h]; exp_c[n_exp] = 3'(h); n_exp++;
                end
            end else begin
                for (int s = 0; s < slots; s++) begin
                    if (32 * s + 24 <= n - 1) begin
                        exp_s[n_exp] = wbuf[s]; exp_c[n_exp] = 3'(s); n_exp++;
                    end
                end
            end
            for (int t = 0; t < n; t++) drive_tick(lvl_of(fmt, t, n), dat_of(fmt, t, n, wl, d, slots));
        end
        drive_tick(lvl_of(fmt, 0, n), 1'b0);
        repeat (6) @(negedge clk);
        cnt = n_got - base;
        check(cnt == n_exp, req, "sample count", cnt, n_exp);
        for (int i = 0; i < n_exp && i < cnt; i++) begin
            check(got_s[(base + i) % 1024] == exp_s[i], req, "sample", int'(got_s[(base + i) % 1024]), int'(exp_s[i]));
            check(got_c[(base + i) % 1024] == exp_c[i], req, "channel", int'(got_c[(base + i) % 1024]), int'(exp_c[i]));
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int fmt, sc, n, wl;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: outputs quiet while in reset.
        check(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
        check(out_sample == '0, "R1", "sample in reset", int'(out_sample), 0);
        check(out_chan == '0, "R1", "chan in reset", int'(out_chan), 0);

        run_stream(0, 1'b0, 0, 0, 24, 2, 64, "R4");
        run_stream(0, 1'b0, 0, 0, 16, 2, 64, "R2 I2S short");
        run_stream(1, 1'b0, 0, 0, 24, 2, 64, "R5 R12");
        run_stream(1, 1'b0, 0, 0, 28, 2, 64, "R3 LJ long");
        run_stream(1, 1'b0, 0, 0, 12, 2, 64, "R2 LJ short");
        run_stream(2, 1'b0, 0, 0, 0, 2, 64, "R6 delay8");
        run_stream(2, 1'b0, 0, 1, 0, 2, 64, "R6 delay12");
        run_stream(2, 1'b0, 0, 2, 0, 2, 64, "R6 delay16");
        run_stream(3, 1'b0, 0, 0, 24, 2, 64, "R7 two slots");
        run_stream(3, 1'b0, 1, 0, 24, 2, 128, "R7 four slots");
        run_stream(3, 1'b0, 2, 0, 30, 2, 256, "R7 R3 eight slots");
        run_stream(4, 1'b0, 1, 0, 24, 2, 200, "R8 extra clocks");
        run_stream(4, 1'b0, 2, 0, 20, 2, 256, "R8 R10 eight slots");
        run_stream(4, 1'b0, 1, 0, 24, 3, 50, "R11 early edge");
        run_stream(1, 1'b1, 0, 0, 24, 2, 64, "R9 LJ inverted");
        run_stream(0, 1'b1, 0, 0, 20, 2, 64, "R9 I2S inverted");

        for (int i = 0; i < 12; i++) begin
            fmt = int'($urandom % 5);
            sc  = int'($urandom % 3);
            if (fmt <= 2) begin
                n  = 64;
                wl = 8 + int'($urandom % 23);
            end else begin
                n  = (fmt == 3) ? 32 * ((sc == 0) ? 2 : (sc == 1) ? 4 : 8) : 64 + int'($urandom % 193);
                wl = 8 + int'($urandom % 25);
            end
            run_stream(fmt, 1'($urandom), sc, int'($urandom % 3), wl, 2, n, "R10 random");
        end
        finish_run();
    end
endmodule